// File: doc/BRIEF.md
# Low-Power Entry Clock Sequencer

This controller takes a chip from run into a stop-class low-power state by switching off clock enables in a fixed order. Entry begins when the processor reports that it is both sleeping and in deep sleep. The core clock is gated at once. The block then raises a stop request to every agent that may still be busy (bus masters, peripherals, the flash controller) and waits for each of them to acknowledge. Once every acknowledge is present, the system, bus and flash clock enables drop together. One cycle later the clock-source and regulator enables named by the target mode are removed.

A wake-up event undoes the sequence in the opposite order. Sources come back first and are given time to settle, then the shared clocks return, and the core clock comes last. A wake-up that arrives while acknowledges are still being collected cancels entry, and the shared clocks are never gated. A debug request, when debug is enabled, uses the same restore path but ends in a halted state with all run clocks running. A state code output exposes the current step.

Top module: `lpe_clk_seq`

## Requirements
- R1: Entry starts from run (state 0) only when `sleeping_i` and `deep_i` are both 1; either one alone leaves the state at 0 and the core clock enable at 1.
- R2: The cycle after a valid request, the state is 1, `core_clk_en_o` is 0, `stop_req_o` is 1 and the system, bus and flash enables are still 1.
- R3: While any bit of `ack_i` is 0 in state 1, the system, bus and flash enables stay 1 and the state stays 1, for as long as that lasts.
- R4: The cycle after all `ack_i` bits are 1 in state 1, the system, bus and flash enables are all 0 and the state is 2.
- R5: One cycle after state 2 the state is 3 (stop). For mode code m the lowest m+1 of the four `src_en_o` bits are 0 and the others are 1. In every other state `src_en_o` is all ones.
- R6: The mode is captured on the cycle entry starts. Changes on `mode_i` after that do not change `src_en_o` in stop.
- R7: A `wake_i` in state 1 returns to state 0 on the next cycle, with `core_clk_en_o` at 1 and `stop_req_o` at 0. The shared clocks are never gated.
- R8: A `wake_i` in stop moves to state 4: all sources on, `stop_req_o` 0, shared and core clocks off. State 4 holds until `src_ready_i` is 1. Then state 5 follows, with shared clocks on and the core clock off. On the next cycle the state is 0 with all clocks on.
- R9: In stop, `dbg_req_i` with `dbg_en_i` takes the same restore path, and it wins over a simultaneous `wake_i`. It ends in state 6 with all clocks on and `halted_o` at 1. State 6 is left for state 0 once `dbg_req_i` drops. `dbg_req_i` with `dbg_en_i` at 0 is ignored.
- R10: After reset the state is 0, all clock and source enables are 1, and `stop_req_o` and `halted_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleeping_i | input | 1 | Processor sleeping indication |
| deep_i | input | 1 | Processor deep-sleep indication |
| mode_i | input | 2 | Target stop mode code |
| ack_i | input | NACK | Stop acknowledges from agents |
| wake_i | input | 1 | Wake-up event |
| dbg_en_i | input | 1 | Debug enabled |
| dbg_req_i | input | 1 | Debug halt request |
| src_ready_i | input | 1 | Clock sources and supply settled |
| core_clk_en_o | output | 1 | Core clock enable |
| sys_clk_en_o | output | 1 | System clock enable |
| bus_clk_en_o | output | 1 | Bus clock enable |
| flash_clk_en_o | output | 1 | Flash clock enable |
| stop_req_o | output | 1 | Stop request to acknowledging agents |
| src_en_o | output | NSRC | Clock source and regulator enables |
| halted_o | output | 1 | Halted under debug |
| state_o | output | 3 | Sequencer state code |

## Verification
Acknowledges arrive as random partial patterns held for random lengths before the full set appears. This separates a sequencer that waits for every agent from one that reacts to any single acknowledge. Every mode code is entered with `mode_i` changed during stop, which shows whether the source mask comes from the captured code or the live one. The exits are tried with wake during polling, wake in stop, debug in stop, debug with debug disabled, and debug and wake together. Each is run with `src_ready_i` held back for a random time. Together these tell apart the abort path, the restore order and the debug priority.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

    localparam int MODE_W  = 2;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_RUN   = 3'd0,
        ST_POLL  = 3'd1,
        ST_GATED = 3'd2,
        ST_STOP  = 3'd3,
        ST_RSRC  = 3'd4,
        ST_RSHR  = 3'd5,
        ST_HALT  = 3'd6
    } lpe_state_e;

    typedef struct packed {
        logic core;
        logic shared;
        logic stop_req;
        logic halted;
    } lpe_ctl_s;

    function automatic lpe_ctl_s ctl_of(lpe_state_e s);
        lpe_ctl_s c;
        c = '0;
        case (s)
            ST_RUN:   begin c.core = 1'b1; c.shared = 1'b1; end
            ST_POLL:  begin c.shared = 1'b1; c.stop_req = 1'b1; end
            ST_GATED: c.stop_req = 1'b1;
            ST_STOP:  c.stop_req = 1'b1;
            ST_RSHR:  c.shared = 1'b1;
            ST_HALT:  begin c.core = 1'b1; c.shared = 1'b1; c.halted = 1'b1; end
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lpe_ack_gather.sv
module lpe_ack_gather #(
    parameter int NACK = 6
) (
    input  logic [NACK-1:0] ack_i,
    output logic            all_ack_o
);
    logic [NACK:0] chain;
    assign chain[0] = 1'b1;
    for (genvar g = 0; g < NACK; g++) begin : g_and
        assign chain[g+1] = chain[g] & ack_i[g];
    end
    assign all_ack_o = chain[NACK];
endmodule

// File: rtl/lpe_src_mask.sv
module lpe_src_mask
    import lpe_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic [MODE_W-1:0] mode_q,
    input  logic              in_stop,
    output logic [NSRC-1:0]   src_en_o
);
    localparam int NMODES = 1 << MODE_W;
    logic [NSRC-1:0] off_mask;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            off_mask[i] = ((i * NMODES) < ((int'(mode_q) + 1) * NSRC));
        end
    end

    assign src_en_o = in_stop ? ~off_mask : '1;
endmodule

// File: rtl/lpe_fsm.sv
module lpe_fsm
    import lpe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              all_ack,
    input  logic              wake,
    input  logic              dbg_go,
    input  logic              dbg_req,
    input  logic              src_ready,
    input  logic [MODE_W-1:0] mode_i,
    output lpe_state_e        state_o,
    output logic [MODE_W-1:0] mode_q
);
    lpe_state_e state, nxt;
    logic       dbg_q;

    always_comb begin
        nxt = state;
        case (state)
            ST_RUN:   if (req) nxt = ST_POLL;
            ST_POLL:  if (wake) nxt = ST_RUN;
                      else if (all_ack) nxt = ST_GATED;
            ST_GATED: nxt = ST_STOP;
            ST_STOP:  if (dbg_go || wake) nxt = ST_RSRC;
            ST_RSRC:  if (src_ready) nxt = ST_RSHR;
            ST_RSHR:  nxt = dbg_q ? ST_HALT : ST_RUN;
            ST_HALT:  if (!dbg_req) nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_RUN;
            mode_q <= '0;
            dbg_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_RUN && req) mode_q <= mode_i;
            if (state == ST_STOP) dbg_q <= dbg_go;
        end
    end

    assign state_o = state;
endmodule

// File: rtl/lpe_clk_seq.sv
module lpe_clk_seq
    import lpe_pkg::*;
#(
    parameter int NACK = 6,
    parameter int NSRC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleeping_i,
    input  logic              deep_i,
    input  logic [1:0]        mode_i,
    input  logic [NACK-1:0]   ack_i,
    input  logic              wake_i,
    input  logic              dbg_en_i,
    input  logic              dbg_req_i,
    input  logic              src_ready_i,
    output logic              core_clk_en_o,
    output logic              sys_clk_en_o,
    output logic              bus_clk_en_o,
    output logic              flash_clk_en_o,
    output logic              stop_req_o,
    output logic [NSRC-1:0]   src_en_o,
    output logic              halted_o,
    output logic [2:0]        state_o
);
    logic              all_ack;
    lpe_state_e        state;
    logic [MODE_W-1:0] mode_q;
    lpe_ctl_s          ctl;

    lpe_ack_gather #(.NACK(NACK)) ack_i_u (
        .ack_i     (ack_i),
        .all_ack_o (all_ack)
    );

    lpe_fsm fsm_u (
        .clk       (clk),
        .rst       (rst),
        .req       (sleeping_i & deep_i),
        .all_ack   (all_ack),
        .wake      (wake_i),
        .dbg_go    (dbg_en_i & dbg_req_i),
        .dbg_req   (dbg_req_i),
        .src_ready (src_ready_i),
        .mode_i    (mode_i),
        .state_o   (state),
        .mode_q    (mode_q)
    );

    lpe_src_mask #(.NSRC(NSRC)) mask_u (
        .mode_q   (mode_q),
        .in_stop  (state == ST_STOP),
        .src_en_o (src_en_o)
    );

    assign ctl            = ctl_of(state);
    assign core_clk_en_o  = ctl.core;
    assign sys_clk_en_o   = ctl.shared;
    assign bus_clk_en_o   = ctl.shared;
    assign flash_clk_en_o = ctl.shared;
    assign stop_req_o     = ctl.stop_req;
    assign halted_o       = ctl.halted;
    assign state_o        = state;
endmodule

// File: rtl/lpe_clk_seq_chk.sv
module lpe_clk_seq_chk #(
    parameter int NACK = 6,
    parameter int NSRC = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            sleeping_i,
    input logic            deep_i,
    input logic [NACK-1:0] ack_i,
    input logic            src_ready_i,
    input logic            core_clk_en_o,
    input logic            sys_clk_en_o,
    input logic            bus_clk_en_o,
    input logic            flash_clk_en_o,
    input logic            stop_req_o,
    input logic [NSRC-1:0] src_en_o,
    input logic            halted_o
);
    // R1
    stop_req_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_req_o) |-> $past(sleeping_i && deep_i));

    // R2
    core_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(core_clk_en_o) |-> sys_clk_en_o && stop_req_o);

    // R4
    shared_off_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_clk_en_o) |-> $past(&ack_i) && !core_clk_en_o
                                && !bus_clk_en_o && !flash_clk_en_o);

    // R5
    src_after_shared_chk: assert property (@(posedge clk) disable iff (rst)
        (src_en_o != '1) |-> !sys_clk_en_o && !bus_clk_en_o && !core_clk_en_o);

    // R8
    shared_back_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_clk_en_o) |-> $past(src_ready_i) && (src_en_o == '1));

    // R8
    core_last_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_clk_en_o) |-> $past(sys_clk_en_o) && !stop_req_o);

    // R9
    halt_clocks_chk: assert property (@(posedge clk) disable iff (rst)
        halted_o |-> core_clk_en_o && flash_clk_en_o && (src_en_o == '1));
endmodule

bind lpe_clk_seq lpe_clk_seq_chk #(.NACK(NACK), .NSRC(NSRC)) chk_u (
    .clk            (clk),
    .rst            (rst),
    .sleeping_i     (sleeping_i),
    .deep_i         (deep_i),
    .ack_i          (ack_i),
    .src_ready_i    (src_ready_i),
    .core_clk_en_o  (core_clk_en_o),
    .sys_clk_en_o   (sys_clk_en_o),
    .bus_clk_en_o   (bus_clk_en_o),
    .flash_clk_en_o (flash_clk_en_o),
    .stop_req_o     (stop_req_o),
    .src_en_o       (src_en_o),
    .halted_o       (halted_o)
);

// File: tb/lpe_clk_seq_tb_top.sv
`timescale 1ns/1ps
module lpe_clk_seq_tb_top;
    localparam int NACK = 6;
    localparam int NSRC = 4;

    logic clk = 1'b0;
    logic rst;
    logic sleeping_i, deep_i, wake_i, dbg_en_i, dbg_req_i, src_ready_i;
    logic [1:0] mode_i;
    logic [NACK-1:0] ack_i;
    logic core_clk_en_o, sys_clk_en_o, bus_clk_en_o, flash_clk_en_o;
    logic stop_req_o, halted_o;
    logic [NSRC-1:0] src_en_o;
    logic [2:0] state_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lpe_clk_seq #(.NACK(NACK), .NSRC(NSRC)) dut_i (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [NSRC-1:0] exp_src(input logic [1:0] m);
        logic [NSRC-1:0] v;
        for (int i = 0; i < NSRC; i++) v[i] = (i > int'(m));
        return v;
    endfunction

    function automatic logic [NACK-1:0] partial_ack();
        logic [NACK-1:0] a;
        a = NACK'($urandom);
        if (a == '1) a[$urandom % NACK] = 1'b0;
        return a;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // clocks packed as {core, sys, bus, flash}
    function automatic int clks();
        return {core_clk_en_o, sys_clk_en_o, bus_clk_en_o, flash_clk_en_o};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic enter(input logic [1:0] m);
        sleeping_i = 1; deep_i = 1; mode_i = m;
        tick();
        sleeping_i = 0; deep_i = 0;
        chk("R2 state", state_o, 1);
        chk("R2 clocks", clks(), 4'b0111);
        chk("R2 stop_req", stop_req_o, 1);
    endtask

    task automatic to_stop(input logic [1:0] m);
        int d;
        enter(m);
        d = $urandom % 5;
        for (int k = 0; k < d; k++) begin
            ack_i = partial_ack();
            tick();
            chk("R3 stall state", state_o, 1);
            chk("R3 stall clocks", clks(), 4'b0111);
        end
        ack_i = '1;
        tick();
        chk("R4 state", state_o, 2);
        chk("R4 shared off", clks(), 4'b0000);
        chk("R5 src still on", src_en_o, 4'hF);
        mode_i = 2'($urandom);
        tick();
        chk("R5 state", state_o, 3);
        chk("R6 R5 src mask", src_en_o, exp_src(m));
    endtask

    task automatic restore(input bit to_halt);
        int r;
        r = $urandom % 4;
        src_ready_i = 0;
        tick();
        wake_i = 0;
        chk("R8 state rsrc", state_o, 4);
        chk("R8 src on", src_en_o, 4'hF);
        chk("R8 stop_req off", stop_req_o, 0);
        chk("R8 clocks off", clks(), 0);
        for (int k = 0; k < r; k++) begin
            tick();
            chk("R8 wait ready", state_o, 4);
        end
        src_ready_i = 1;
        tick();
        src_ready_i = 0;
        chk("R8 state rshr", state_o, 5);
        chk("R8 shared before core", clks(), 4'b0111);
        ack_i = '0;
        tick();
        if (to_halt) begin
            chk("R9 halt state", state_o, 6);
            chk("R9 halted", halted_o, 1);
            chk("R9 clocks", clks(), 4'b1111);
            dbg_req_i = 0;
            tick();
        end
        chk("R8 R9 run", state_o, 0);
        chk("R8 core on", clks(), 4'b1111);
        chk("R8 halted off", halted_o, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; sleeping_i = 0; deep_i = 0; wake_i = 0; dbg_en_i = 0;
        dbg_req_i = 0; src_ready_i = 0; mode_i = 0; ack_i = '0;
        tick(); tick();
        rst = 0;
        chk("R10 state", state_o, 0);
        chk("R10 clocks", clks(), 4'b1111);
        chk("R10 src", src_en_o, 4'hF);
        chk("R10 stop_req", stop_req_o, 0);
        chk("R10 halted", halted_o, 0);

        sleeping_i = 1;
        tick();
        chk("R1 sleeping only", state_o, 0);
        chk("R1 core on", core_clk_en_o, 1);
        sleeping_i = 0; deep_i = 1;
        tick();
        chk("R1 deep only", state_o, 0);
        deep_i = 0;

        // directed: each mode, plain wake
        for (int m = 0; m < 4; m++) begin
            to_stop(2'(m));
            wake_i = 1;
            restore(0);
        end

        // directed: debug disabled is ignored, then debug + wake
        to_stop(2'd2);
        dbg_req_i = 1;
        tick();
        chk("R9 ignored without enable", state_o, 3);
        chk("R9 src unchanged", src_en_o, exp_src(2'd2));
        dbg_en_i = 1; wake_i = 1;
        restore(1);
        dbg_en_i = 0;

        // random mix
        for (int it = 0; it < 40; it++) begin
            logic [1:0] m;
            int kind;
            m = 2'($urandom);
            kind = $urandom % 4;
            if (kind == 0) begin
                enter(m);
                ack_i = partial_ack();
                tick();
                chk("R3 stall", clks(), 4'b0111);
                wake_i = 1;
                tick();
                wake_i = 0;
                ack_i = '0;
                chk("R7 abort state", state_o, 0);
                chk("R7 clocks", clks(), 4'b1111);
                chk("R7 stop_req", stop_req_o, 0);
            end else begin
                to_stop(m);
                for (int k = 0; k < int'($urandom % 3); k++) begin
                    tick();
                    chk("R5 stop held", src_en_o, exp_src(m));
                end
                if (kind == 1) begin
                    dbg_en_i = 1; dbg_req_i = 1;
                    restore(1);
                    dbg_en_i = 0;
                end else begin
                    wake_i = 1;
                    restore(0);
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule